// File: doc/BRIEF.md
# Demodulate Window and Phase Rotator

This block sits on both sides of an external NP-point FFT in a cyclic-spectrum front end. On the way into the FFT, each complex sample of a frame is scaled by an analysis-window coefficient, selected by the sample's position within the frame. On the way out of the FFT, each bin is multiplied by a down-conversion phase term that depends on the bin number and the frame number.

The frame stride is a quarter of the frame length, so the phase term is always a whole number of quarter turns. The block therefore needs no complex multiplier on the output side. A two-bit rotation index picks one of four cases: pass through, swap with one negation, negate both parts, or swap with the other negation.

Window coefficients are loaded through a simple write port before or between frames. Each path is a valid/ready stream with one register stage. Each path carries its own tags, and the two paths run independently of each other.

Top module: `demod_rotator`

## Requirements
- R1: While rst_n is low, and right after it is released, win_out_valid and rot_out_valid are 0 and win_in_ready and rot_in_ready are 1.
- R2: Window path: each output part equals (x·c + 2^(CW-2)) arithmetically shifted right by CW-1, keeping the low SW bits. Here x is the signed input part and c is the unsigned coefficient stored at address win_in_idx, in fixed point with 1 integer bit (2^(CW-1) means 1.0).
- R3: A write with coef_we high stores coef_data at coef_addr on that clock edge. A window sample accepted on the same edge still uses the old value, and every sample accepted on a later edge uses the new value.
- R4: Rotation path: q = (rot_in_bin · rot_in_frame) mod 4. For q=0 the output is (re, im). For q=1 it is (im, −re). For q=2 it is (−re, −im). For q=3 it is (−im, re).
- R5: Negating the most negative SW-bit value gives the most positive value instead of wrapping.
- R6: Each output carries the index/bin and frame tags of the input it was computed from.
- R7: Both paths have a latency of one cycle. An input accepted on an edge is presented as valid after that edge. A path with its output ready accepts one input every cycle.
- R8: While an output is valid and not ready, its data and tags hold, and no result is lost or duplicated.
- R9: Backpressure on one path does not slow or alter the other path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | AW | Coefficient address (sample index) |
| coef_data | input | CW | Coefficient value, unsigned, 1 integer bit |
| win_in_valid | input | 1 | Window path input valid |
| win_in_ready | output | 1 | Window path input ready |
| win_in_idx | input | AW | Sample index within the frame |
| win_in_frame | input | FW | Frame number tag |
| win_in_re | input | SW | Sample real part |
| win_in_im | input | SW | Sample imaginary part |
| win_out_valid | output | 1 | Window path output valid |
| win_out_ready | input | 1 | Window path output ready |
| win_out_idx | output | AW | Sample index tag |
| win_out_frame | output | FW | Frame tag |
| win_out_re | output | SW | Windowed real part |
| win_out_im | output | SW | Windowed imaginary part |
| rot_in_valid | input | 1 | Rotation path input valid |
| rot_in_ready | output | 1 | Rotation path input ready |
| rot_in_bin | input | AW | FFT bin number |
| rot_in_frame | input | FW | Frame number |
| rot_in_re | input | SW | Bin real part |
| rot_in_im | input | SW | Bin imaginary part |
| rot_out_valid | output | 1 | Rotation path output valid |
| rot_out_ready | input | 1 | Rotation path output ready |
| rot_out_bin | output | AW | Bin tag |
| rot_out_frame | output | FW | Frame tag |
| rot_out_re | output | SW | Rotated real part |
| rot_out_im | output | SW | Rotated imaginary part |

## Verification
The window path is tested with three fixed coefficients: unity, zero and full scale. These show whether rounding and truncation use the right bit positions. Random coefficients, including rewrites during traffic, expose the write/read ordering. The rotation path is tested with bin and frame pairs that reach all four quarter-turn cases, including large operands whose product wraps. The most negative value is placed on each part so that saturated negation can be told apart from a wrap or a wrong swap. Random, independent backpressure on the two paths, and a long stall of one path while the other streams, separate correct holding from dropped, repeated or cross-coupled results.

// File: rtl/demod_rotator.sv
module demod_rotator #(
  parameter int SW = 16,
  parameter int CW = 16,
  parameter int NP = 256,
  parameter int FW = 8,
  localparam int AW = $clog2(NP)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 coef_we,
  input  logic [AW-1:0]        coef_addr,
  input  logic [CW-1:0]        coef_data,
  input  logic                 win_in_valid,
  output logic                 win_in_ready,
  input  logic [AW-1:0]        win_in_idx,
  input  logic [FW-1:0]        win_in_frame,
  input  logic signed [SW-1:0] win_in_re,
  input  logic signed [SW-1:0] win_in_im,
  output logic                 win_out_valid,
  input  logic                 win_out_ready,
  output logic [AW-1:0]        win_out_idx,
  output logic [FW-1:0]        win_out_frame,
  output logic signed [SW-1:0] win_out_re,
  output logic signed [SW-1:0] win_out_im,
  input  logic                 rot_in_valid,
  output logic                 rot_in_ready,
  input  logic [AW-1:0]        rot_in_bin,
  input  logic [FW-1:0]        rot_in_frame,
  input  logic signed [SW-1:0] rot_in_re,
  input  logic signed [SW-1:0] rot_in_im,
  output logic                 rot_out_valid,
  input  logic                 rot_out_ready,
  output logic [AW-1:0]        rot_out_bin,
  output logic [FW-1:0]        rot_out_frame,
  output logic signed [SW-1:0] rot_out_re,
  output logic signed [SW-1:0] rot_out_im
);
  localparam int PW = SW + CW + 1;
  localparam logic signed [SW-1:0] SMAX = {1'b0, {(SW-1){1'b1}}};
  localparam logic signed [SW-1:0] SMIN = {1'b1, {(SW-1){1'b0}}};
  localparam logic signed [PW-1:0] RND  = {{(PW-1){1'b0}}, 1'b1} << (CW-2);

  logic [CW-1:0] coef_mem [NP];
  logic [CW-1:0] coef;

  always_ff @(posedge clk)
    if (coef_we) coef_mem[coef_addr] <= coef_data;

  assign coef = coef_mem[win_in_idx];

  function automatic logic signed [SW-1:0] scale(input logic signed [SW-1:0] x,
                                                 input logic [CW-1:0] c);
    logic signed [PW-1:0] p;
    p = $signed({{(CW+1){x[SW-1]}}, x}) * $signed({{(SW+1){1'b0}}, c}) + RND;
    return p[CW-1 +: SW];
  endfunction

  function automatic logic signed [SW-1:0] neg(input logic signed [SW-1:0] x);
    return (x == SMIN) ? SMAX : -x;
  endfunction

  assign win_in_ready = !win_out_valid || win_out_ready;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            win_out_valid <= 1'b0;
    else if (win_in_ready) win_out_valid <= win_in_valid;

  always_ff @(posedge clk)
    if (win_in_valid && win_in_ready) begin
      win_out_idx   <= win_in_idx;
      win_out_frame <= win_in_frame;
      win_out_re    <= scale(win_in_re, coef);
      win_out_im    <= scale(win_in_im, coef);
    end

  logic [1:0] quarter;
  logic signed [SW-1:0] rre, rim;

  assign quarter = rot_in_bin[1:0] * rot_in_frame[1:0];

  always_comb
    case (quarter)
      2'd0:    begin rre = rot_in_re;      rim = rot_in_im;      end
      2'd1:    begin rre = rot_in_im;      rim = neg(rot_in_re); end
      2'd2:    begin rre = neg(rot_in_re); rim = neg(rot_in_im); end
      default: begin rre = neg(rot_in_im); rim = rot_in_re;      end
    endcase

  assign rot_in_ready = !rot_out_valid || rot_out_ready;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            rot_out_valid <= 1'b0;
    else if (rot_in_ready) rot_out_valid <= rot_in_valid;

  always_ff @(posedge clk)
    if (rot_in_valid && rot_in_ready) begin
      rot_out_bin   <= rot_in_bin;
      rot_out_frame <= rot_in_frame;
      rot_out_re    <= rre;
      rot_out_im    <= rim;
    end
endmodule

// File: rtl/demod_rotator_chk.sv
module demod_rotator_chk #(
  parameter int SW = 16,
  parameter int CW = 16,
  parameter int NP = 256,
  parameter int FW = 8,
  localparam int AW = $clog2(NP)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 win_in_valid,
  input logic                 win_in_ready,
  input logic [AW-1:0]        win_in_idx,
  input logic [FW-1:0]        win_in_frame,
  input logic                 win_out_valid,
  input logic                 win_out_ready,
  input logic [AW-1:0]        win_out_idx,
  input logic [FW-1:0]        win_out_frame,
  input logic signed [SW-1:0] win_out_re,
  input logic signed [SW-1:0] win_out_im,
  input logic                 rot_in_valid,
  input logic                 rot_in_ready,
  input logic [AW-1:0]        rot_in_bin,
  input logic [FW-1:0]        rot_in_frame,
  input logic signed [SW-1:0] rot_in_re,
  input logic signed [SW-1:0] rot_in_im,
  input logic                 rot_out_valid,
  input logic                 rot_out_ready,
  input logic [AW-1:0]        rot_out_bin,
  input logic [FW-1:0]        rot_out_frame,
  input logic signed [SW-1:0] rot_out_re,
  input logic signed [SW-1:0] rot_out_im
);
  localparam logic signed [SW-1:0] SMAX = {1'b0, {(SW-1){1'b1}}};
  localparam logic signed [SW-1:0] SMIN = {1'b1, {(SW-1){1'b0}}};

  logic win_fire, rot_fire;
  logic [1:0] rot_q;
  assign win_fire = win_in_valid && win_in_ready;
  assign rot_fire = rot_in_valid && rot_in_ready;
  assign rot_q = 2'((32'(rot_in_bin) * 32'(rot_in_frame)) % 4);

  // R7
  win_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_fire |=> win_out_valid);
  // R7
  rot_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rot_fire |=> rot_out_valid);
  // R8
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_out_valid && !win_out_ready |=> win_out_valid && $stable(win_out_re)
      && $stable(win_out_im) && $stable(win_out_idx) && $stable(win_out_frame));
  // R8
  rot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rot_out_valid && !rot_out_ready |=> rot_out_valid && $stable(rot_out_re)
      && $stable(rot_out_im) && $stable(rot_out_bin) && $stable(rot_out_frame));
  // R6
  win_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_fire |=> win_out_idx == $past(win_in_idx) && win_out_frame == $past(win_in_frame));
  // R6
  rot_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rot_fire |=> rot_out_bin == $past(rot_in_bin) && rot_out_frame == $past(rot_in_frame));
  // R4
  rot_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rot_fire && rot_q == 2'd0 |=> rot_out_re == $past(rot_in_re) && rot_out_im == $past(rot_in_im));
  // R5
  rot_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rot_fire && rot_q == 2'd2 && rot_in_re == SMIN |=> rot_out_re == SMAX);
endmodule

bind demod_rotator demod_rotator_chk #(.SW(SW), .CW(CW), .NP(NP), .FW(FW)) u_chk (.*);

// File: tb/demod_rotator_bench.sv
module demod_rotator_bench;
  localparam int SW = 16, CW = 16, NP = 256, FW = 8;
  localparam int AW = $clog2(NP);
  localparam int IW = AW + FW + 2*SW;
  localparam logic [SW-1:0] SMAX = {1'b0, {(SW-1){1'b1}}};
  localparam logic [SW-1:0] SMIN = {1'b1, {(SW-1){1'b0}}};
  typedef logic [IW-1:0] item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic coef_we = 0; logic [AW-1:0] coef_addr = '0; logic [CW-1:0] coef_data = '0;
  logic win_in_valid = 0, win_in_ready, win_out_valid, win_out_ready = 0;
  logic [AW-1:0] win_in_idx = '0, win_out_idx; logic [FW-1:0] win_in_frame = '0, win_out_frame;
  logic [SW-1:0] win_in_re = '0, win_in_im = '0, win_out_re, win_out_im;
  logic rot_in_valid = 0, rot_in_ready, rot_out_valid, rot_out_ready = 0;
  logic [AW-1:0] rot_in_bin = '0, rot_out_bin; logic [FW-1:0] rot_in_frame = '0, rot_out_frame;
  logic [SW-1:0] rot_in_re = '0, rot_in_im = '0, rot_out_re, rot_out_im;

  demod_rotator u_demod_rotator (.*);

  int unsigned n_vec = 0, n_bad = 0, win_got = 0, rot_got = 0;
  int unsigned win_vpct = 100, rot_vpct = 100, win_rpct = 100, rot_rpct = 100;
  bit random_mode = 0, win_done = 0, rot_done = 0;
  logic [CW-1:0] coef_ref [NP];
  item_t win_src[$], rot_src[$], win_exp[$], rot_exp[$];

  function automatic logic [SW-1:0] wscale(logic signed [SW-1:0] x, logic [CW-1:0] c);
    longint p;
    p = longint'(x) * longint'(c) + (longint'(1) << (CW-2));
    p = p >>> (CW-1);
    return p[SW-1:0];
  endfunction

  function automatic logic [SW-1:0] sneg(logic [SW-1:0] x);
    return (x == SMIN) ? SMAX : -x;
  endfunction

  function automatic item_t win_model(item_t it);
    logic [AW-1:0] a; logic [FW-1:0] f; logic [SW-1:0] r, i;
    {a, f, r, i} = it;
    return {a, f, wscale(r, coef_ref[a]), wscale(i, coef_ref[a])};
  endfunction

  function automatic item_t rot_model(item_t it);
    logic [AW-1:0] b; logic [FW-1:0] f; logic [SW-1:0] r, i; int q;
    {b, f, r, i} = it;
    q = (int'(b) * int'(f)) % 4;
    case (q)
      0: return {b, f, r, i};
      1: return {b, f, i, sneg(r)};
      2: return {b, f, sneg(r), sneg(i)};
      default: return {b, f, sneg(i), r};
    endcase
  endfunction

  task automatic check(string req, item_t act, item_t exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic item_t rand_item();
    logic [SW-1:0] r, i;
    r = ($urandom_range(7) == 0) ? SMIN : SW'($urandom);
    i = ($urandom_range(7) == 0) ? SMIN : SW'($urandom);
    return {AW'($urandom), FW'($urandom), r, i};
  endfunction

  task automatic cycle();
    @(negedge clk);
    if (win_done) win_in_valid = 0;
    if (rot_done) rot_in_valid = 0;
    if (random_mode && win_src.size() == 0) win_src.push_back(rand_item());
    if (random_mode && rot_src.size() == 0) rot_src.push_back(rand_item());
    if (!win_in_valid && win_src.size() > 0 && $urandom_range(99) < win_vpct) begin
      {win_in_idx, win_in_frame, win_in_re, win_in_im} = win_src.pop_front();
      win_in_valid = 1;
    end
    if (!rot_in_valid && rot_src.size() > 0 && $urandom_range(99) < rot_vpct) begin
      {rot_in_bin, rot_in_frame, rot_in_re, rot_in_im} = rot_src.pop_front();
      rot_in_valid = 1;
    end
    win_out_ready = $urandom_range(99) < win_rpct;
    rot_out_ready = $urandom_range(99) < rot_rpct;
    coef_we = random_mode && ($urandom_range(15) == 0);
    coef_addr = AW'($urandom); coef_data = CW'($urandom);
    #3;
    win_done = win_in_valid && win_in_ready;
    rot_done = rot_in_valid && rot_in_ready;
    if (win_done) win_exp.push_back(win_model({win_in_idx, win_in_frame, win_in_re, win_in_im}));
    if (rot_done) rot_exp.push_back(rot_model({rot_in_bin, rot_in_frame, rot_in_re, rot_in_im}));
    if (win_out_valid && win_out_ready) begin
      win_got++;
      if (win_exp.size() == 0) check_bit("R7 spurious window output", 1'b1, 1'b0);
      else check("R2 R3 R6 R8 window", {win_out_idx, win_out_frame, win_out_re, win_out_im}, win_exp.pop_front());
    end
    if (rot_out_valid && rot_out_ready) begin
      rot_got++;
      if (rot_exp.size() == 0) check_bit("R7 spurious rotation output", 1'b1, 1'b0);
      else check("R4 R5 R6 R8 rotation", {rot_out_bin, rot_out_frame, rot_out_re, rot_out_im}, rot_exp.pop_front());
    end
    if (coef_we) coef_ref[coef_addr] = coef_data;
  endtask

  task automatic write_coef(int a, logic [CW-1:0] v);
    @(negedge clk);
    coef_we = 1; coef_addr = AW'(a); coef_data = v;
    @(negedge clk);
    coef_we = 0;
    coef_ref[a] = v;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int unsigned w0, r0;
    process::self().srandom(32'd20260214);
    repeat (3) @(negedge clk);
    // R1 reset state
    check_bit("R1 win_out_valid", win_out_valid, 1'b0);
    check_bit("R1 rot_out_valid", rot_out_valid, 1'b0);
    check_bit("R1 win_in_ready", win_in_ready, 1'b1);
    check_bit("R1 rot_in_ready", rot_in_ready, 1'b1);
    rst_n = 1;
    @(negedge clk);
    check_bit("R1 valid after release", win_out_valid | rot_out_valid, 1'b0);

    for (int a = 0; a < NP; a++) write_coef(a, CW'($urandom));
    write_coef(5, CW'(1) << (CW-1));
    write_coef(6, '0);
    write_coef(7, '1);

    // R2 R3 directed coefficients: unity, zero, full scale
    win_src.push_back({AW'(5), FW'(1), SMIN, SMAX});
    win_src.push_back({AW'(5), FW'(1), SW'(16'h1234), SW'(-16'sd3)});
    win_src.push_back({AW'(6), FW'(2), SMAX, SMIN});
    win_src.push_back({AW'(7), FW'(3), SMIN, SMAX});
    win_src.push_back({AW'(7), FW'(3), SW'(1), SW'(-1)});
    // R4 R5 quarter turns and saturated negation
    rot_src.push_back({AW'(4), FW'(9), SW'(100), SW'(-7)});
    rot_src.push_back({AW'(1), FW'(1), SMIN, SW'(55)});
    rot_src.push_back({AW'(2), FW'(1), SMIN, SMIN});
    rot_src.push_back({AW'(3), FW'(1), SW'(9), SMIN});
    rot_src.push_back({AW'(3), FW'(3), SW'(-20), SW'(30)});
    rot_src.push_back({AW'(255), FW'(255), SW'(1), SW'(2)});
    rot_src.push_back({AW'(6), FW'(3), SMAX, SMIN});
    repeat (12) cycle();

    // R7 back-to-back acceptance, one output per cycle
    w0 = win_got; r0 = rot_got;
    for (int k = 0; k < 10; k++) begin
      win_src.push_back(rand_item());
      rot_src.push_back(rand_item());
    end
    repeat (11) cycle();
    check("R7 window throughput", item_t'(win_got - w0), item_t'(10));
    check("R7 rotation throughput", item_t'(rot_got - r0), item_t'(10));

    // R9 rotation path stalled while window path streams
    rot_rpct = 0;
    w0 = win_got;
    for (int k = 0; k < 20; k++) begin
      win_src.push_back(rand_item());
      rot_src.push_back(rand_item());
    end
    repeat (21) cycle();
    check("R9 window unaffected by rotation stall", item_t'(win_got - w0), item_t'(20));
    check_bit("R9 rotation held valid", rot_out_valid, 1'b1);
    rot_rpct = 100;
    repeat (25) cycle();
    win_src.delete(); rot_src.delete();

    // random traffic with backpressure and coefficient rewrites (R3 R8)
    random_mode = 1;
    win_vpct = 75; rot_vpct = 75; win_rpct = 70; rot_rpct = 60;
    repeat (4000) cycle();
    random_mode = 0;
    win_vpct = 100; rot_vpct = 100; win_rpct = 100; rot_rpct = 100;
    repeat (10) cycle();
    check("R7 window drained", item_t'(win_exp.size()), item_t'(0));
    check("R7 rotation drained", item_t'(rot_exp.size()), item_t'(0));

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule